// File: doc/BRIEF.md
# Graphics Object Binding Validator

This unit holds the per-object state of the active drawing object in a 2D drawing engine. It keeps two 32-bit words. The control word carries the object class, the selected raster operation, the colour-key, clip and swizzle flags, and a render-enable bit. The validity word records which helper objects are bound: surfaces, pattern, raster-op, single-factor blend and four-factor blend.

The command front end issues one method per cycle. A method does one of three things:

- It loads the class of the active object.
- It selects an operation.
- It binds a helper object. The method carries the helper's class code and the slot it targets.

Each accepted method updates the relevant flags. It also recomputes render-enable from the operation, the object class and the set of bound helpers. A rejected method changes nothing and raises a one-cycle error pulse.

Pixel rendering, fetching object records from memory and DMA are outside this block.

Top module: `obj_bind_validator`

## Requirements
- R1: After reset both words read zero, and `render_en_o` and `err_o` are low.
- R2: Kind 0 (load class) writes `data_i` into control bits 7:0. It is always accepted.
- R3: Kind 1 (select operation) writes `data_i[2:0]` into control bits 17:15. Values above 5 are rejected. Values 3, 4 and 5 are also rejected when the stored class is below 0x40.
- R4: A rejected method leaves both words unchanged, and `err_o` is high for exactly the following cycle. Kind 3 is always rejected. Slot codes 13 to 15 are always rejected.
- R5: Kind 2 (bind) with class 0x30 clears the slot's flag. The slot's own class sets the flag. Any other class is rejected. The slots are:

  | Slot | Helper | Class | Flag |
  |------|--------|-------|------|
  | 0 | old-generation pattern | 0x18 | valid bit 27 |
  | 1 | new-generation pattern | 0x44 | valid bit 27 |
  | 2 | raster-op | 0x43 | valid bit 28 |
  | 3 | single-factor blend | 0x12 | valid bit 29 |
  | 4 | four-factor blend | 0x72 | valid bit 30 |
  | 5 | destination surface | 0x58 | valid bit 25 |
  | 6 | source surface | 0x59 | valid bit 26 |
  | 7 | colour surface | 0x5A | valid bit 25 |
  | 8 | depth surface | 0x5B | valid bit 26 |

  All other validity bits stay zero.
- R6: Slot 9 (plain 2D surface) accepts 0x42 or 0x30. Slot 10 (2D surface with swizzle) accepts 0x42, 0x52 or 0x30. In both slots, 0x42 sets valid bit 25 and clears control bit 14. On slot 10, 0x52 sets both valid bit 25 and control bit 14. On either slot, 0x30 clears both bits.
- R7: Slot 11 (clip) sets control bit 13 for class 0x19. Slot 12 (colour key) sets control bit 12 for class 0x57. Class 0x30 clears the slot's bit.
- R8: Render-enable requires valid bit 25. Classes 0x1F and 0x48 also need valid bit 26. The operation adds further needs:
  - operations 0 and 3 need nothing more;
  - operation 1 needs bits 27 and 28;
  - operation 2 needs bit 29;
  - operations 4 and 5 need bit 30.
- R9: Every accepted method re-evaluates render-enable, including an operation change that leaves the validity word as it was. The result appears on control bit 24 and `render_en_o` in the cycle after the method.
- R10: With `mthd_valid_i` low, both words hold and `err_o` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mthd_valid_i | input | 1 | A method is presented this cycle |
| mthd_kind_i | input | 2 | 0 load class, 1 select operation, 2 bind, 3 reserved |
| slot_i | input | 4 | Bind slot code (used only by kind 2) |
| data_i | input | 8 | Class code, or operation value |
| ctrl_word_o | output | 32 | Control word |
| valid_word_o | output | 32 | Validity word |
| render_en_o | output | 1 | Render-enable, a copy of control bit 24 |
| err_o | output | 1 | One-cycle pulse after a rejected method |

## Verification
The assertions assume that the inputs are settled at each rising edge, and that `mthd_kind_i`, `slot_i` and `data_i` are known whenever `mthd_valid_i` is high. The bench drives every input on the falling edge and presents each method for exactly one cycle. It drops `mthd_valid_i` between methods, so each error pulse and each state change can be tied to a single method. Reserved kinds, reserved slots and foreign class codes are sent on purpose. This checks that the rejection path holds state, rather than the design merely leaving those codes undefined.

// File: rtl/obj_bind_pkg.sv
package obj_bind_pkg;
  localparam int WORD_W = 32;
  localparam int CLS_W  = 8;
  localparam int OP_W   = 3;
  localparam int SLOT_W = 4;

  localparam int CB_KEY  = 12;
  localparam int CB_CLIP = 13;
  localparam int CB_SWZ  = 14;
  localparam int CB_OP   = 15;
  localparam int CB_REN  = 24;
  localparam int VB_DST  = 25;
  localparam int VB_SRC  = 26;
  localparam int VB_PAT  = 27;
  localparam int VB_ROP  = 28;
  localparam int VB_B1   = 29;
  localparam int VB_B4   = 30;

  localparam logic [CLS_W-1:0] CLS_NULL = 8'h30;

  typedef enum logic [1:0] {
    MK_CLASS = 2'd0,
    MK_OP    = 2'd1,
    MK_BIND  = 2'd2,
    MK_RSVD  = 2'd3
  } mthd_kind_e;

  typedef enum logic [SLOT_W-1:0] {
    SL_PAT_OLD = 4'd0,
    SL_PAT_NEW = 4'd1,
    SL_ROP     = 4'd2,
    SL_BLEND1  = 4'd3,
    SL_BLEND4  = 4'd4,
    SL_DST     = 4'd5,
    SL_SRC     = 4'd6,
    SL_COLOR   = 4'd7,
    SL_DEPTH   = 4'd8,
    SL_SURF2D  = 4'd9,
    SL_SURF2DS = 4'd10,
    SL_CLIP    = 4'd11,
    SL_KEY     = 4'd12
  } slot_e;
endpackage

// File: rtl/bind_decode.sv
module bind_decode
  import obj_bind_pkg::*;
(
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [CLS_W-1:0]  cls_i,
  output logic              ok_o,
  output logic [WORD_W-1:0] ctrl_mask_o,
  output logic [WORD_W-1:0] ctrl_val_o,
  output logic [WORD_W-1:0] vld_mask_o,
  output logic [WORD_W-1:0] vld_val_o
);
  logic              in_ctrl;
  logic [4:0]        bit_idx;
  logic [CLS_W-1:0]  set_cls;
  logic              is_null, is_set, is_swz, surf2d;

  always_comb begin
    in_ctrl = 1'b0;
    bit_idx = 5'(VB_DST);
    set_cls = 8'h00;
    surf2d  = 1'b0;
    unique case (slot_i)
      SL_PAT_OLD: begin bit_idx = 5'(VB_PAT); set_cls = 8'h18; end
      SL_PAT_NEW: begin bit_idx = 5'(VB_PAT); set_cls = 8'h44; end
      SL_ROP:     begin bit_idx = 5'(VB_ROP); set_cls = 8'h43; end
      SL_BLEND1:  begin bit_idx = 5'(VB_B1);  set_cls = 8'h12; end
      SL_BLEND4:  begin bit_idx = 5'(VB_B4);  set_cls = 8'h72; end
      SL_DST:     begin bit_idx = 5'(VB_DST); set_cls = 8'h58; end
      SL_SRC:     begin bit_idx = 5'(VB_SRC); set_cls = 8'h59; end
      SL_COLOR:   begin bit_idx = 5'(VB_DST); set_cls = 8'h5A; end
      SL_DEPTH:   begin bit_idx = 5'(VB_SRC); set_cls = 8'h5B; end
      SL_SURF2D, SL_SURF2DS: begin
        bit_idx = 5'(VB_DST); set_cls = 8'h42; surf2d = 1'b1;
      end
      SL_CLIP:    begin in_ctrl = 1'b1; bit_idx = 5'(CB_CLIP); set_cls = 8'h19; end
      SL_KEY:     begin in_ctrl = 1'b1; bit_idx = 5'(CB_KEY);  set_cls = 8'h57; end
      default:    set_cls = 8'h00;
    endcase
  end

  assign is_null = (cls_i == CLS_NULL);
  assign is_set  = (cls_i == set_cls) && (set_cls != 8'h00);
  assign is_swz  = (slot_i == SL_SURF2DS) && (cls_i == 8'h52);

  always_comb begin
    ok_o        = (slot_i <= SL_KEY) && (is_null || is_set || is_swz);
    ctrl_mask_o = '0;
    ctrl_val_o  = '0;
    vld_mask_o  = '0;
    vld_val_o   = '0;
    if (in_ctrl) begin
      ctrl_mask_o[bit_idx] = 1'b1;
      ctrl_val_o[bit_idx]  = !is_null;
    end else begin
      vld_mask_o[bit_idx]  = 1'b1;
      vld_val_o[bit_idx]   = !is_null;
    end
    if (surf2d) begin
      // swizzle flag follows the surface kind; plain/null clears it
      ctrl_mask_o[CB_SWZ] = 1'b1;
      ctrl_val_o[CB_SWZ]  = is_swz;
    end
  end
endmodule

// File: rtl/render_gate.sv
module render_gate
  import obj_bind_pkg::*;
(
  input  logic [CLS_W-1:0]  cls_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [WORD_W-1:0] vld_i,
  output logic              en_o
);
  logic need_src, op_ok;

  assign need_src = (cls_i == 8'h1F) || (cls_i == 8'h48);

  always_comb begin
    unique case (op_i)
      3'd0, 3'd3: op_ok = 1'b1;
      3'd1:       op_ok = vld_i[VB_PAT] && vld_i[VB_ROP];
      3'd2:       op_ok = vld_i[VB_B1];
      3'd4, 3'd5: op_ok = vld_i[VB_B4];
      default:    op_ok = 1'b0;
    endcase
  end

  assign en_o = vld_i[VB_DST] && (!need_src || vld_i[VB_SRC]) && op_ok;
endmodule

// File: rtl/obj_bind_validator.sv
module obj_bind_validator
  import obj_bind_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mthd_valid_i,
  input  logic [1:0]        mthd_kind_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [CLS_W-1:0]  data_i,
  output logic [WORD_W-1:0] ctrl_word_o,
  output logic [WORD_W-1:0] valid_word_o,
  output logic              render_en_o,
  output logic              err_o
);
  localparam logic [CLS_W-1:0] OLD_CLS_LIMIT = 8'h40;
  localparam int               OP_MAX        = 5;

  logic [WORD_W-1:0] ctrl_q, vld_q, ctrl_pre, ctrl_n, vld_n;
  logic [WORD_W-1:0] b_cmask, b_cval, b_vmask, b_vval;
  logic              b_ok, accept, en_n, err_q;
  mthd_kind_e        kind;

  assign kind = mthd_kind_e'(mthd_kind_i);

  bind_decode u_dec (
    .slot_i      (slot_i),
    .cls_i       (data_i),
    .ok_o        (b_ok),
    .ctrl_mask_o (b_cmask),
    .ctrl_val_o  (b_cval),
    .vld_mask_o  (b_vmask),
    .vld_val_o   (b_vval)
  );

  always_comb begin
    ctrl_pre = ctrl_q;
    vld_n    = vld_q;
    accept   = 1'b0;
    unique case (kind)
      MK_CLASS: begin
        accept = 1'b1;
        ctrl_pre[CLS_W-1:0] = data_i;
      end
      MK_OP: begin
        accept = (int'(data_i) <= OP_MAX) &&
                 !((data_i > 8'd2) && (ctrl_q[CLS_W-1:0] < OLD_CLS_LIMIT));
        ctrl_pre[CB_OP +: OP_W] = data_i[OP_W-1:0];
      end
      MK_BIND: begin
        accept   = b_ok;
        ctrl_pre = (ctrl_q & ~b_cmask) | b_cval;
        vld_n    = (vld_q & ~b_vmask) | b_vval;
      end
      default: accept = 1'b0;
    endcase
  end

  render_gate u_gate (
    .cls_i (ctrl_pre[CLS_W-1:0]),
    .op_i  (ctrl_pre[CB_OP +: OP_W]),
    .vld_i (vld_n),
    .en_o  (en_n)
  );

  always_comb begin
    ctrl_n         = ctrl_pre;
    ctrl_n[CB_REN] = en_n;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      vld_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= mthd_valid_i && !accept;
      if (mthd_valid_i && accept) begin
        ctrl_q <= ctrl_n;
        vld_q  <= vld_n;
      end
    end
  end

  assign ctrl_word_o  = ctrl_q;
  assign valid_word_o = vld_q;
  assign render_en_o  = ctrl_q[CB_REN];
  assign err_o        = err_q;
endmodule

// File: rtl/obj_bind_validator_chk.sv
module obj_bind_validator_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        mthd_valid_i,
  input logic [1:0]  mthd_kind_i,
  input logic [3:0]  slot_i,
  input logic [7:0]  data_i,
  input logic [31:0] ctrl_word_o,
  input logic [31:0] valid_word_o,
  input logic        render_en_o,
  input logic        err_o
);
  p_err_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ($stable(ctrl_word_o) && $stable(valid_word_o)));

  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mthd_valid_i |=> ($stable(ctrl_word_o) && $stable(valid_word_o) && !err_o));

  p_ren_dst_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    render_en_o |-> valid_word_o[25]);

  p_op_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_word_o[17:15] <= 3'd5);

  p_op_reject_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mthd_valid_i && mthd_kind_i == 2'd1 && data_i > 8'd5) |=> err_o);

  p_rsv_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_word_o[24:0] == 25'd0) && !valid_word_o[31]);
endmodule

bind obj_bind_validator obj_bind_validator_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mthd_valid_i (mthd_valid_i),
  .mthd_kind_i  (mthd_kind_i),
  .slot_i       (slot_i),
  .data_i       (data_i),
  .ctrl_word_o  (ctrl_word_o),
  .valid_word_o (valid_word_o),
  .render_en_o  (render_en_o),
  .err_o        (err_o)
);

// File: tb/obj_bind_validator_tb.sv
module obj_bind_validator_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mv = 1'b0;
  logic [1:0]  kind = '0;
  logic [3:0]  slot = '0;
  logic [7:0]  data = '0;
  logic [31:0] ctrl, vld;
  logic        ren, err;
  int          n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  obj_bind_validator u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mthd_valid_i(mv), .mthd_kind_i(kind),
    .slot_i(slot), .data_i(data), .ctrl_word_o(ctrl), .valid_word_o(vld),
    .render_en_o(ren), .err_o(err)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one-cycle method; returns at the falling edge after the capturing edge
  task automatic mthd(input logic [1:0] k, input logic [3:0] s, input logic [7:0] d);
    kind = k; slot = s; data = d; mv = 1'b1;
    @(negedge clk);
    mv = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 ctrl", ctrl, 32'h0);
    chk("R1 valid", vld, 32'h0);
    chk("R1 ren/err", {ren, err}, 2'b00);
  endtask

  task automatic t_class_op;
    mthd(2'd0, 4'd0, 8'h5F);
    chk("R2 class", ctrl[7:0], 8'h5F);
    mthd(2'd1, 4'd0, 8'd4);
    chk("R3 op accepted", ctrl[17:15], 3'd4);
    chk("R3 no err", err, 1'b0);
    mthd(2'd1, 4'd0, 8'd6);
    chk("R3 op>5 err", err, 1'b1);
    chk("R4 op unchanged", ctrl[17:15], 3'd4);
    @(negedge clk);
    chk("R4 err one cycle", err, 1'b0);
    mthd(2'd0, 4'd0, 8'h21);
    mthd(2'd1, 4'd0, 8'd2);
    chk("R3 old class op2", ctrl[17:15], 3'd2);
    mthd(2'd1, 4'd0, 8'd3);
    chk("R3 old class op3 err", err, 1'b1);
    chk("R3 old class op kept", ctrl[17:15], 3'd2);
    mthd(2'd3, 4'd0, 8'h00);
    chk("R4 rsvd kind err", err, 1'b1);
    chk("R4 rsvd kind ctrl", ctrl, 32'h0001_0021);
  endtask

  task automatic t_bind_flags;
    logic [31:0] c0;
    mthd(2'd2, 4'd2, 8'h43);
    chk("R5 rop set", vld, 32'h1000_0000);
    mthd(2'd2, 4'd0, 8'h18);
    chk("R5 old pattern set", vld[27], 1'b1);
    mthd(2'd2, 4'd1, 8'h30);
    chk("R5 null clears pattern", vld[27], 1'b0);
    mthd(2'd2, 4'd1, 8'h18);
    chk("R5 wrong pattern class err", err, 1'b1);
    chk("R5 wrong class no change", vld, 32'h1000_0000);
    mthd(2'd2, 4'd3, 8'h12);
    mthd(2'd2, 4'd4, 8'h72);
    mthd(2'd2, 4'd6, 8'h59);
    chk("R5 blends and src", vld, 32'h7400_0000);
    mthd(2'd2, 4'd8, 8'h30);
    chk("R5 depth null clears bit26", vld[26], 1'b0);
    mthd(2'd2, 4'd7, 8'h5A);
    chk("R5 colour sets bit25", vld[25], 1'b1);
    c0 = ctrl;
    mthd(2'd2, 4'd13, 8'h30);
    chk("R4 rsvd slot err", err, 1'b1);
    chk("R4 rsvd slot ctrl", ctrl, c0);
    mthd(2'd2, 4'd5, 8'h30);
    chk("R5 dst null", vld, 32'h7000_0000);
    // R10 idle cycles
    repeat (3) @(negedge clk);
    chk("R10 idle hold", vld, 32'h7000_0000);
    chk("R10 idle no err", err, 1'b0);
  endtask

  task automatic t_surf2d;
    mthd(2'd2, 4'd10, 8'h52);
    chk("R6 swz sets bit14", ctrl[14], 1'b1);
    chk("R6 swz sets dst", vld[25], 1'b1);
    mthd(2'd2, 4'd9, 8'h42);
    chk("R6 plain clears swz", {ctrl[14], vld[25]}, 2'b01);
    mthd(2'd2, 4'd9, 8'h52);
    chk("R6 plain slot rejects 0x52", err, 1'b1);
    chk("R6 swz still clear", ctrl[14], 1'b0);
    mthd(2'd2, 4'd10, 8'h52);
    mthd(2'd2, 4'd10, 8'h30);
    chk("R6 null clears both", {ctrl[14], vld[25]}, 2'b00);
  endtask

  task automatic t_clip_key;
    mthd(2'd2, 4'd11, 8'h19);
    chk("R7 clip set", ctrl[13], 1'b1);
    mthd(2'd2, 4'd12, 8'h17);
    chk("R7 key rejects 0x17", {err, ctrl[12]}, 2'b10);
    mthd(2'd2, 4'd12, 8'h57);
    chk("R7 key set", ctrl[12], 1'b1);
    mthd(2'd2, 4'd11, 8'h30);
    chk("R7 clip null", ctrl[13:12], 2'b01);
  endtask

  task automatic t_render;
    // clear helpers
    for (int s = 0; s <= 10; s++) mthd(2'd2, 4'(s), 8'h30);
    mthd(2'd0, 4'd0, 8'h5F);
    mthd(2'd1, 4'd0, 8'd0);
    chk("R8 no dst no ren", ren, 1'b0);
    mthd(2'd2, 4'd5, 8'h58);
    chk("R9 ren after bind", ren, 1'b1);
    chk("R9 ren on bit24", ctrl[24], 1'b1);
    mthd(2'd1, 4'd0, 8'd1);
    chk("R9 op change drops ren", ren, 1'b0);
    mthd(2'd2, 4'd1, 8'h44);
    chk("R8 op1 pattern only", ren, 1'b0);
    mthd(2'd2, 4'd2, 8'h43);
    chk("R8 op1 pattern+rop", ren, 1'b1);
    mthd(2'd1, 4'd0, 8'd2);
    chk("R8 op2 needs blend1", ren, 1'b0);
    mthd(2'd2, 4'd3, 8'h12);
    chk("R8 op2 blend1", ren, 1'b1);
    mthd(2'd1, 4'd0, 8'd5);
    chk("R8 op5 needs blend4", ren, 1'b0);
    mthd(2'd2, 4'd4, 8'h72);
    chk("R8 op5 blend4", ren, 1'b1);
    mthd(2'd1, 4'd0, 8'd3);
    chk("R8 op3 dst only", ren, 1'b1);
    mthd(2'd1, 4'd0, 8'd0);
    mthd(2'd0, 4'd0, 8'h1F);
    chk("R8 class 0x1F needs src", ren, 1'b0);
    mthd(2'd2, 4'd6, 8'h59);
    chk("R8 class 0x1F with src", ren, 1'b1);
    mthd(2'd2, 4'd7, 8'h30);
    chk("R8 colour null drops ren", ren, 1'b0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_class_op();
    t_bind_flags();
    t_surf2d();
    t_clip_key();
    t_render();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule